// File: doc/BRIEF.md
# Legacy Paravirtual I/O Register Header

This block holds the register header that a backward-compatible paravirtual device exposes at the start of its I/O region. The host reaches it through a simple register access port. Each access has a byte offset, a size of one, two or four bytes, and write data. The header has these fields:

- the device feature word, which is read-only
- the driver feature word, which the driver writes
- a per-queue page number for queue memory
- a per-queue size, a queue selector, and a queue notify field
- a device status byte
- an interrupt-status byte that clears when it is read

When message-signalled interrupts are switched on, two 16-bit vector registers follow the header. One is the configuration vector and the other is the vector of the selected queue.

The bytes that follow the header belong to a device-specific window. That window starts at offset 20 while message-signalled interrupts are off and at offset 24 while they are on. Accesses into the window pass unchanged to the device logic, with the offset taken relative to the window start. The device logic supplies its own read data. Writing zero to the status byte returns the whole header to its reset state and sends a one-cycle reset pulse to the device.

Top module: `legio_hdr`

## Requirements
- R1: A read (`acc_valid`=1, `acc_write`=0) sets `rd_valid` for exactly the next cycle, with `rd_data` holding the result. Values are right-justified from bit 0. A write never sets `rd_valid`.
- R2: Size codes are 0 for one byte, 1 for two bytes and 2 for four bytes. A header field is reached only at its own start offset and with its own size. Any other header access ignores the write and reads 0.
- R3: Offset 0, size 2, reads `dev_feat` and ignores writes. Offset 4, size 2, is the driver feature word. It reads back what was written, drives `drv_feat`, and resets to 0. Only 32 feature bits exist.
- R4: The queue selector is at offset 14, size 1. For a selected queue below NUM_Q:
  - offset 8, size 2, reads and writes that queue's page number (physical address divided by 4096);
  - offset 12, size 1, reads QSIZE.
  For a selector at or above NUM_Q, both fields read 0 and page-number writes are ignored.
- R5: A size-1 write of value v to offset 16 pulses `notify_valid` for one cycle, with `notify_idx`=v, in the cycle after the access, provided v < NUM_Q. Other values cause no pulse. Reads of offset 16 return 0.
- R6: The status byte is at offset 18, size 0. It reads back a nonzero written value, drives `dev_status`, and is 0 after reset.
- R7: Writing 0 to the status byte has the following effects:
  - it clears the driver features, the selector, the status, the pending interrupt bits and every page number;
  - it sets every vector to 0xFFFF;
  - it pulses `dev_reset` in the next cycle.
- R8: Each `isr_set` bit ORs into a 2-bit pending register, and `irq` is the OR of that register. While message-signalled interrupts are off, a size-0 read of offset 19 returns the pending bits and clears them. A bit set in the same cycle as the read is kept.
- R9: While `msix_en`=1, a read of offset 19 returns 0 and leaves the pending bits unchanged. Two vector registers are then available:
  - offset 20, size 1: the configuration vector;
  - offset 22, size 1: the selected queue's vector.
  Both reset to 0xFFFF. A written value of NUM_VEC or more is stored as 0xFFFF.
- R10: The device window starts at offset 20 when `msix_en`=0 and at 24 when it is 1. An access at or beyond the start drives `dev_valid`, `dev_write`, `dev_size`, `dev_wdata` and `dev_offset`, where `dev_offset` is the offset minus the start. Its read returns `dev_rdata` with R1 timing. Accesses below the start never reach the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| msix_en | input | 1 | Message-signalled interrupts enabled |
| dev_feat | input | 32 | Device feature bits |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset in the region |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_wdata | input | 32 | Right-justified write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| drv_feat | output | 32 | Features acknowledged by the driver |
| dev_status | output | 8 | Device status byte |
| dev_reset | output | 1 | One-cycle reset pulse |
| isr_set | input | 2 | Interrupt cause set pulses |
| irq | output | 1 | Pending interrupt line |
| notify_valid | output | 1 | Queue notify pulse |
| notify_idx | output | 16 | Notified queue index |
| dev_valid | output | 1 | Device window access |
| dev_write | output | 1 | Window access is a write |
| dev_offset | output | ADDR_W | Offset within the window |
| dev_size | output | 2 | Window access size |
| dev_wdata | output | 32 | Window write data |
| dev_rdata | input | 32 | Window read data |

## Verification
Some properties are checked on every cycle:
- the read-valid timing;
- that a notify pulse always names an existing queue and follows a notify write;
- the reset pulse and cleared status after a zero status write;
- the lowered interrupt line after a clearing read;
- that offsets inside the header never reach the device window.

Other behaviours depend on stored values, so only the directed scenarios can show them:
- the per-queue page numbers and vectors that follow the selector;
- the clamping of out-of-range vectors to 0xFFFF;
- the shift of the window start when message-signalled interrupts are toggled;
- the wholesale clearing of header state by a zero status write.

// File: rtl/legio_pkg.sv
package legio_pkg;

    typedef enum logic [3:0] {
        FLD_NONE,
        FLD_DFEAT,
        FLD_GFEAT,
        FLD_PFN,
        FLD_QSIZE,
        FLD_QSEL,
        FLD_NOTIFY,
        FLD_STATUS,
        FLD_ISR,
        FLD_CVEC,
        FLD_QVEC,
        FLD_DEV
    } fld_e;

    localparam logic [1:0] SZ_B = 2'd0;
    localparam logic [1:0] SZ_H = 2'd1;
    localparam logic [1:0] SZ_W = 2'd2;

    localparam int OFF_DFEAT  = 0;
    localparam int OFF_GFEAT  = 4;
    localparam int OFF_PFN    = 8;
    localparam int OFF_QSIZE  = 12;
    localparam int OFF_QSEL   = 14;
    localparam int OFF_NOTIFY = 16;
    localparam int OFF_STATUS = 18;
    localparam int OFF_ISR    = 19;
    localparam int OFF_CVEC   = 20;
    localparam int OFF_QVEC   = 22;
    localparam int WIN_BASE_PLAIN = 20;
    localparam int WIN_BASE_MSIX  = 24;

    localparam int ISR_W = 2;
    localparam logic [15:0] NO_VEC = 16'hFFFF;

    function automatic logic [15:0] clamp_vec(input logic [15:0] v, input int unsigned nvec);
        return (32'(v) < nvec) ? v : NO_VEC;
    endfunction

endpackage

// File: rtl/legio_decode.sv
module legio_decode
    import legio_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              msix_en,
    output fld_e              fld,
    output logic [ADDR_W-1:0] win_off
);

    localparam logic [ADDR_W-1:0] BASE_PLAIN = ADDR_W'(WIN_BASE_PLAIN);
    localparam logic [ADDR_W-1:0] BASE_MSIX  = ADDR_W'(WIN_BASE_MSIX);

    logic [ADDR_W-1:0] base;

    always_comb begin
        base    = msix_en ? BASE_MSIX : BASE_PLAIN;
        fld     = FLD_NONE;
        win_off = '0;
        if (addr >= base) begin
            fld     = FLD_DEV;
            win_off = addr - base;
        end else begin
            case (addr)
                ADDR_W'(OFF_DFEAT):  if (size == SZ_W) fld = FLD_DFEAT;
                ADDR_W'(OFF_GFEAT):  if (size == SZ_W) fld = FLD_GFEAT;
                ADDR_W'(OFF_PFN):    if (size == SZ_W) fld = FLD_PFN;
                ADDR_W'(OFF_QSIZE):  if (size == SZ_H) fld = FLD_QSIZE;
                ADDR_W'(OFF_QSEL):   if (size == SZ_H) fld = FLD_QSEL;
                ADDR_W'(OFF_NOTIFY): if (size == SZ_H) fld = FLD_NOTIFY;
                ADDR_W'(OFF_STATUS): if (size == SZ_B) fld = FLD_STATUS;
                ADDR_W'(OFF_ISR):    if (size == SZ_B) fld = FLD_ISR;
                ADDR_W'(OFF_CVEC):   if (size == SZ_H && msix_en) fld = FLD_CVEC;
                ADDR_W'(OFF_QVEC):   if (size == SZ_H && msix_en) fld = FLD_QVEC;
                default:             fld = FLD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/legio_qbank.sv
module legio_qbank
    import legio_pkg::*;
#(
    parameter int NUM_Q   = 4,
    parameter int NUM_VEC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic [15:0] sel,
    input  logic        pfn_we,
    input  logic        vec_we,
    input  logic [31:0] wdata,
    output logic        sel_ok,
    output logic [31:0] pfn_rd,
    output logic [15:0] vec_rd
);

    typedef struct packed {
        logic [NUM_Q-1:0][31:0] pfn;
        logic [NUM_Q-1:0][15:0] vec;
    } qst_t;

    qst_t q_q, q_d;
    logic [NUM_Q-1:0] hit;

    assign sel_ok = (32'(sel) < 32'(NUM_Q));

    for (genvar g = 0; g < NUM_Q; g++) begin : g_hit
        assign hit[g] = sel_ok && (32'(sel) == g);
    end

    always_comb begin
        q_d = q_q;
        for (int i = 0; i < NUM_Q; i++) begin
            if (clr) begin
                q_d.pfn[i] = '0;
                q_d.vec[i] = NO_VEC;
            end else begin
                if (pfn_we && hit[i]) q_d.pfn[i] = wdata;
                if (vec_we && hit[i]) q_d.vec[i] = clamp_vec(wdata[15:0], NUM_VEC);
            end
        end
    end

    always_comb begin
        pfn_rd = '0;
        vec_rd = NO_VEC;
        for (int i = 0; i < NUM_Q; i++) begin
            if (hit[i]) begin
                pfn_rd = q_q.pfn[i];
                vec_rd = q_q.vec[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_Q; i++) begin
                q_q.pfn[i] <= '0;
                q_q.vec[i] <= NO_VEC;
            end
        end else begin
            q_q <= q_d;
        end
    end

endmodule

// File: rtl/legio_hdr.sv
module legio_hdr
    import legio_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_Q   = 4,
    parameter int NUM_VEC = 8,
    parameter int QSIZE   = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msix_en,
    input  logic [31:0]       dev_feat,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic [31:0]       drv_feat,
    output logic [7:0]        dev_status,
    output logic              dev_reset,
    input  logic [1:0]        isr_set,
    output logic              irq,
    output logic              notify_valid,
    output logic [15:0]       notify_idx,
    output logic              dev_valid,
    output logic              dev_write,
    output logic [ADDR_W-1:0] dev_offset,
    output logic [1:0]        dev_size,
    output logic [31:0]       dev_wdata,
    input  logic [31:0]       dev_rdata
);

    localparam logic [15:0] QSIZE_V = 16'(QSIZE);
    localparam logic [15:0] NQ_V    = 16'(NUM_Q);

    typedef struct packed {
        logic [31:0]      gfeat;
        logic [15:0]      qsel;
        logic [7:0]       status;
        logic [ISR_W-1:0] isr;
        logic [15:0]      cvec;
        logic             rvalid;
        logic [31:0]      rdata;
        logic             nvalid;
        logic [15:0]      nidx;
        logic             dreset;
    } st_t;

    st_t st_q, st_d;

    fld_e              fld;
    logic [ADDR_W-1:0] win_off;
    logic              rd_acc, wr_acc, status_clr;
    logic              sel_ok;
    logic [31:0]       pfn_rd;
    logic [15:0]       vec_rd;
    logic [31:0]       rmux;

    legio_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (acc_addr),
        .size    (acc_size),
        .msix_en (msix_en),
        .fld     (fld),
        .win_off (win_off)
    );

    assign rd_acc     = acc_valid && !acc_write;
    assign wr_acc     = acc_valid && acc_write;
    assign status_clr = wr_acc && (fld == FLD_STATUS) && (acc_wdata[7:0] == 8'h00);

    legio_qbank #(.NUM_Q(NUM_Q), .NUM_VEC(NUM_VEC)) u_qbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (status_clr),
        .sel    (st_q.qsel),
        .pfn_we (wr_acc && (fld == FLD_PFN)),
        .vec_we (wr_acc && (fld == FLD_QVEC)),
        .wdata  (acc_wdata),
        .sel_ok (sel_ok),
        .pfn_rd (pfn_rd),
        .vec_rd (vec_rd)
    );

    always_comb begin
        case (fld)
            FLD_DFEAT:  rmux = dev_feat;
            FLD_GFEAT:  rmux = st_q.gfeat;
            FLD_PFN:    rmux = pfn_rd;
            FLD_QSIZE:  rmux = {16'h0, (sel_ok ? QSIZE_V : 16'h0)};
            FLD_QSEL:   rmux = {16'h0, st_q.qsel};
            FLD_STATUS: rmux = {24'h0, st_q.status};
            FLD_ISR:    rmux = msix_en ? 32'h0 : {{(32-ISR_W){1'b0}}, st_q.isr};
            FLD_CVEC:   rmux = {16'h0, st_q.cvec};
            FLD_QVEC:   rmux = {16'h0, vec_rd};
            FLD_DEV:    rmux = dev_rdata;
            default:    rmux = 32'h0;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.nvalid = 1'b0;
        st_d.dreset = 1'b0;
        st_d.isr    = st_q.isr | isr_set;

        if (rd_acc) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rmux;
            if (fld == FLD_ISR && !msix_en) st_d.isr = isr_set;
        end

        if (wr_acc) begin
            case (fld)
                FLD_GFEAT: st_d.gfeat = acc_wdata;
                FLD_QSEL:  st_d.qsel  = acc_wdata[15:0];
                FLD_NOTIFY: begin
                    if (acc_wdata[15:0] < NQ_V) begin
                        st_d.nvalid = 1'b1;
                        st_d.nidx   = acc_wdata[15:0];
                    end
                end
                FLD_STATUS: begin
                    if (status_clr) begin
                        st_d.gfeat  = '0;
                        st_d.qsel   = '0;
                        st_d.status = '0;
                        st_d.isr    = '0;
                        st_d.cvec   = NO_VEC;
                        st_d.dreset = 1'b1;
                    end else begin
                        st_d.status = acc_wdata[7:0];
                    end
                end
                FLD_CVEC:  st_d.cvec = clamp_vec(acc_wdata[15:0], NUM_VEC);
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gfeat  <= '0;
            st_q.qsel   <= '0;
            st_q.status <= '0;
            st_q.isr    <= '0;
            st_q.cvec   <= NO_VEC;
            st_q.rvalid <= 1'b0;
            st_q.rdata  <= '0;
            st_q.nvalid <= 1'b0;
            st_q.nidx   <= '0;
            st_q.dreset <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid     = st_q.rvalid;
    assign rd_data      = st_q.rdata;
    assign drv_feat     = st_q.gfeat;
    assign dev_status   = st_q.status;
    assign dev_reset    = st_q.dreset;
    assign irq          = |st_q.isr;
    assign notify_valid = st_q.nvalid;
    assign notify_idx   = st_q.nidx;

    assign dev_valid  = acc_valid && (fld == FLD_DEV);
    assign dev_write  = acc_write;
    assign dev_offset = win_off;
    assign dev_size   = acc_size;
    assign dev_wdata  = acc_wdata;

endmodule

// File: rtl/legio_hdr_chk.sv
module legio_hdr_chk #(
    parameter int ADDR_W = 8,
    parameter int NUM_Q  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msix_en,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_size,
    input logic [31:0]       acc_wdata,
    input logic [1:0]        isr_set,
    input logic              rd_valid,
    input logic              irq,
    input logic              notify_valid,
    input logic [15:0]       notify_idx,
    input logic              dev_valid,
    input logic [7:0]        dev_status,
    input logic              dev_reset
);

    logic zero_status_wr, isr_rd, notify_wr;

    assign zero_status_wr = acc_valid && acc_write && (32'(acc_addr) == 18)
                            && (acc_size == 2'd0) && ((acc_wdata & 32'hFF) == 32'h0);
    assign isr_rd = acc_valid && !acc_write && (32'(acc_addr) == 19)
                    && (acc_size == 2'd0) && !msix_en && (isr_set == 2'b00);
    assign notify_wr = acc_valid && acc_write && (32'(acc_addr) == 16) && (acc_size == 2'd1);

    p_rd_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> rd_valid);

    p_no_spurious_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !rd_valid);

    p_notify_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> (32'(notify_idx) < NUM_Q));

    p_notify_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !notify_wr |=> !notify_valid);

    p_zero_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_status_wr |=> (dev_reset && dev_status == 8'h00 && !irq));

    p_isr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        isr_rd |=> !irq);

    p_hdr_private_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && 32'(acc_addr) < 20) |-> !dev_valid);

    p_msix_hdr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && msix_en && 32'(acc_addr) < 24) |-> !dev_valid);

endmodule

bind legio_hdr legio_hdr_chk #(.ADDR_W(ADDR_W), .NUM_Q(NUM_Q)) u_chk (.*);

// File: tb/legio_hdr_test.sv
module legio_hdr_test;

    localparam int ADDR_W = 8;
    localparam int NUM_Q  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              msix_en = 1'b0;
    logic [31:0]       dev_feat = 32'hC0DE_1234;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [1:0]        acc_size = '0;
    logic [31:0]       acc_wdata = '0;
    logic              rd_valid;
    logic [31:0]       rd_data;
    logic [31:0]       drv_feat;
    logic [7:0]        dev_status;
    logic              dev_reset;
    logic [1:0]        isr_set = '0;
    logic              irq;
    logic              notify_valid;
    logic [15:0]       notify_idx;
    logic              dev_valid;
    logic              dev_write;
    logic [ADDR_W-1:0] dev_offset;
    logic [1:0]        dev_size;
    logic [31:0]       dev_wdata;
    logic [31:0]       dev_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic        s_rvalid, s_nvalid, s_dreset, s_dvalid, s_dwrite;
    logic [31:0] s_rdata;
    logic [15:0] s_nidx;
    logic [7:0]  s_doff;

    always #10 clk = ~clk;

    assign dev_rdata = 32'hDE00_0000 | {24'h0, dev_offset};

    legio_hdr uut (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic access(input logic wr, input int addr, input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_addr  = ADDR_W'(addr);
        acc_size  = sz;
        acc_wdata = wd;
        #1;
        s_dvalid = dev_valid;
        s_dwrite = dev_write;
        s_doff   = dev_offset;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
        s_rvalid = rd_valid;
        s_rdata  = rd_data;
        s_nvalid = notify_valid;
        s_nidx   = notify_idx;
        s_dreset = dev_reset;
    endtask

    task automatic t_reset_state;
        check("R6 status after reset", 32'(dev_status), 32'h0);
        check("R8 irq after reset", 32'(irq), 32'h0);
        check("R3 drv_feat after reset", drv_feat, 32'h0);
        check("R1 rd_valid idle", 32'(rd_valid), 32'h0);
        msix_en = 1'b1;
        access(1'b0, 20, 2'd1, 0);
        check("R9 cfg vector reset", s_rdata, 32'hFFFF);
        msix_en = 1'b0;
    endtask

    task automatic t_features;
        access(1'b0, 0, 2'd2, 0);
        check("R1 rd_valid after read", 32'(s_rvalid), 32'h1);
        check("R3 device features", s_rdata, 32'hC0DE_1234);
        access(1'b1, 0, 2'd2, 32'h1111_1111);
        check("R1 no rd_valid after write", 32'(s_rvalid), 32'h0);
        access(1'b0, 0, 2'd2, 0);
        check("R3 device features read-only", s_rdata, 32'hC0DE_1234);
        access(1'b1, 4, 2'd2, 32'hA5A5_0F0F);
        access(1'b0, 4, 2'd2, 0);
        check("R3 driver features readback", s_rdata, 32'hA5A5_0F0F);
        check("R3 drv_feat port", drv_feat, 32'hA5A5_0F0F);
        access(1'b1, 4, 2'd1, 32'h0000_0001);
        check("R2 wrong-size write ignored", drv_feat, 32'hA5A5_0F0F);
        access(1'b0, 5, 2'd0, 0);
        check("R2 unaligned read zero", s_rdata, 32'h0);
    endtask

    task automatic t_queues;
        access(1'b0, 12, 2'd1, 0);
        check("R4 queue 0 size", s_rdata, 32'd256);
        access(1'b1, 8, 2'd2, 32'h0001_2345);
        access(1'b1, 14, 2'd1, 2);
        access(1'b1, 8, 2'd2, 32'h0000_0777);
        access(1'b0, 14, 2'd1, 0);
        check("R4 selector readback", s_rdata, 32'd2);
        access(1'b1, 14, 2'd1, 0);
        access(1'b0, 8, 2'd2, 0);
        check("R4 queue 0 page number", s_rdata, 32'h0001_2345);
        access(1'b1, 14, 2'd1, 2);
        access(1'b0, 8, 2'd2, 0);
        check("R4 queue 2 page number", s_rdata, 32'h0000_0777);
        access(1'b1, 14, 2'd1, 5);
        access(1'b1, 8, 2'd2, 32'h0000_0999);
        access(1'b0, 8, 2'd2, 0);
        check("R4 absent queue page reads 0", s_rdata, 32'h0);
        access(1'b0, 12, 2'd1, 0);
        check("R4 absent queue size reads 0", s_rdata, 32'h0);
        access(1'b1, 14, 2'd1, 2);
        access(1'b0, 8, 2'd2, 0);
        check("R4 absent-queue write left queue 2", s_rdata, 32'h0000_0777);
    endtask

    task automatic t_notify;
        access(1'b1, 16, 2'd1, 3);
        check("R5 notify pulse", 32'(s_nvalid), 32'h1);
        check("R5 notify index", 32'(s_nidx), 32'd3);
        @(negedge clk);
        check("R5 notify one cycle", 32'(notify_valid), 32'h0);
        access(1'b1, 16, 2'd1, 9);
        check("R5 out-of-range notify", 32'(s_nvalid), 32'h0);
        access(1'b0, 16, 2'd1, 0);
        check("R5 notify reads 0", s_rdata, 32'h0);
    endtask

    task automatic t_isr;
        msix_en = 1'b0;
        @(negedge clk);
        isr_set = 2'b01;
        @(negedge clk);
        isr_set = 2'b00;
        check("R8 irq raised", 32'(irq), 32'h1);
        access(1'b0, 19, 2'd0, 0);
        check("R8 isr read value", s_rdata, 32'h1);
        check("R8 irq cleared by read", 32'(irq), 32'h0);
        @(negedge clk);
        isr_set = 2'b10;
        @(negedge clk);
        isr_set = 2'b00;
        msix_en = 1'b1;
        access(1'b0, 19, 2'd0, 0);
        check("R9 isr reads 0 with msix", s_rdata, 32'h0);
        check("R9 isr kept with msix", 32'(irq), 32'h1);
        msix_en = 1'b0;
        access(1'b0, 19, 2'd0, 0);
        check("R8 isr value after msix", s_rdata, 32'h2);
        check("R8 irq cleared", 32'(irq), 32'h0);
    endtask

    task automatic t_vectors;
        msix_en = 1'b1;
        access(1'b1, 20, 2'd1, 5);
        access(1'b0, 20, 2'd1, 0);
        check("R9 config vector", s_rdata, 32'd5);
        access(1'b1, 20, 2'd1, 100);
        access(1'b0, 20, 2'd1, 0);
        check("R9 config vector clamp", s_rdata, 32'hFFFF);
        access(1'b1, 14, 2'd1, 1);
        access(1'b1, 22, 2'd1, 3);
        access(1'b1, 14, 2'd1, 0);
        access(1'b0, 22, 2'd1, 0);
        check("R9 queue 0 vector untouched", s_rdata, 32'hFFFF);
        access(1'b1, 14, 2'd1, 1);
        access(1'b0, 22, 2'd1, 0);
        check("R9 queue 1 vector", s_rdata, 32'd3);
        access(1'b1, 22, 2'd1, 8);
        access(1'b0, 22, 2'd1, 0);
        check("R9 queue vector clamp", s_rdata, 32'hFFFF);
        msix_en = 1'b0;
    endtask

    task automatic t_window;
        msix_en = 1'b0;
        access(1'b0, 20, 2'd2, 0);
        check("R10 plain window hit", 32'(s_dvalid), 32'h1);
        check("R10 plain window offset", 32'(s_doff), 32'h0);
        check("R10 plain window data", s_rdata, 32'hDE00_0000);
        msix_en = 1'b1;
        access(1'b0, 20, 2'd1, 0);
        check("R10 msix vector not window", 32'(s_dvalid), 32'h0);
        access(1'b0, 24, 2'd2, 0);
        check("R10 msix window offset", 32'(s_doff), 32'h0);
        check("R10 msix window data", s_rdata, 32'hDE00_0000);
        access(1'b1, 30, 2'd1, 32'h55);
        check("R10 window write flag", 32'(s_dwrite), 32'h1);
        check("R10 window write offset", 32'(s_doff), 32'd6);
        msix_en = 1'b0;
        access(1'b0, 18, 2'd0, 0);
        check("R10 header not window", 32'(s_dvalid), 32'h0);
    endtask

    task automatic t_status_reset;
        msix_en = 1'b1;
        access(1'b1, 18, 2'd0, 32'h0F);
        check("R6 status port", 32'(dev_status), 32'h0F);
        access(1'b0, 18, 2'd0, 0);
        check("R6 status readback", s_rdata, 32'h0F);
        access(1'b1, 20, 2'd1, 2);
        access(1'b1, 14, 2'd1, 0);
        @(negedge clk);
        isr_set = 2'b01;
        @(negedge clk);
        isr_set = 2'b00;
        access(1'b1, 18, 2'd0, 32'h0);
        check("R7 reset pulse", 32'(s_dreset), 32'h1);
        check("R7 status cleared", 32'(dev_status), 32'h0);
        check("R7 drv_feat cleared", drv_feat, 32'h0);
        check("R7 irq cleared", 32'(irq), 32'h0);
        @(negedge clk);
        check("R7 reset pulse one cycle", 32'(dev_reset), 32'h0);
        access(1'b0, 8, 2'd2, 0);
        check("R7 page number cleared", s_rdata, 32'h0);
        access(1'b0, 20, 2'd1, 0);
        check("R7 config vector reset", s_rdata, 32'hFFFF);
        access(1'b1, 14, 2'd1, 1);
        access(1'b0, 22, 2'd1, 0);
        check("R7 queue vector reset", s_rdata, 32'hFFFF);
        msix_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_features();
        t_queues();
        t_notify();
        t_isr();
        t_vectors();
        t_window();
        t_status_reset();
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule